// File: doc/BRIEF.md
# Serial Synthesizer Word Loader

This block receives programming words for a frequency synthesizer over a three-wire serial port made of a data line, a serial clock and a load-enable line. While load-enable is low, each rising serial-clock edge shifts one data bit into an 18-bit shift register, most significant bit first. The last bit shifted in is the address bit. The 17 bits ahead of it are the payload.

When load-enable rises, the address bit selects one of two holding-latch groups, and that group loads the payload in parallel. Address 0 selects the divider group: a 4-bit swallow count, a 12-bit main divide count and one idle bit. Address 1 selects the reference group: an 11-bit reference divide count, a 3-bit control/test field and a 3-bit pump-current field. The latch outputs drive the counters and the control logic. Only reset clears them, so they keep their values through any power-down mode that the control fields select.

The serial lines are sampled by the system clock `clk`. The serial clock runs well below `clk`, so each edge is seen by comparing the line with its value one `clk` earlier.

Top module: `serial_prog_port`

## Requirements
- R1: While `rst_n` is low, every latch output is zero. At the first `clk` edge after reset, no shift and no load take place.
- R2: When `clk` samples `ser_clk` high one cycle after sampling it low, and `ser_le` is low, the shift register moves one place towards its MSB and takes `ser_data` into bit 0. The first bit sent therefore ends up in bit 17, and the last bit sent in bit 0, where it serves as the address.
- R3: Rising `ser_clk` edges while `ser_le` is high do not shift.
- R4: On a rising `ser_le` with address 0, the divider group loads from word bits [17:1]: `idle_bit` from bit 17, `n_val` from bits 16:5 and `a_val` from bits 4:1.
- R5: On a rising `ser_le` with address 1, the reference group loads from word bits [17:1]: `cp_bits` from bits 17:15, `ctl_bits` from bits 14:12 and `r_val` from bits 11:1.
- R6: A load changes only the addressed group. The other group keeps its contents.
- R7: If more than 18 bits are sent before `ser_le` rises, only the last 18 are used. If fewer are sent, the register still holds earlier bits beneath the new ones, and the load uses that whole 18-bit content.
- R8: The latch outputs do not change while `ser_le` stays low or stays high, whatever happens on the data and clock lines.
- R9: If `ser_clk` rises in the same `clk` sample in which `ser_le` rises, that edge does not shift. The load uses the register content from before that edge.
- R10: The loaded values appear at the outputs after the `clk` edge that first samples `ser_le` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load enable: shifting while low, parallel load on its rising edge |
| a_val | output | 4 | Swallow-count latch |
| n_val | output | 12 | Main-divide latch |
| idle_bit | output | 1 | Idle latch bit |
| r_val | output | 11 | Reference-divide latch |
| ctl_bits | output | 3 | Control/test latch |
| cp_bits | output | 3 | Pump-current latch |

## Verification
The shift and the parallel load can fall in the same `clk` sample, when a serial-clock rise arrives together with the rise of load-enable. The bench provokes this by raising both lines at one falling `clk` edge, after words of random length. It then expects the loaded values to come from the word without that final bit, following a reference register that the bench updates itself. A second source of conflict is a short word that is loaded over the remains of earlier ones. The random mix of word lengths and addresses covers it, and the bench judges it by comparing all six latch fields after every load.

// File: rtl/serial_prog_port.sv
module serial_prog_port #(
  parameter int A_W  = 4,
  parameter int N_W  = 12,
  parameter int R_W  = 11,
  parameter int CT_W = 3,
  parameter int CP_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ser_clk,
  input  logic            ser_data,
  input  logic            ser_le,
  output logic [A_W-1:0]  a_val,
  output logic [N_W-1:0]  n_val,
  output logic            idle_bit,
  output logic [R_W-1:0]  r_val,
  output logic [CT_W-1:0] ctl_bits,
  output logic [CP_W-1:0] cp_bits
);
  localparam int PAY_W  = A_W + N_W + 1;
  localparam int WORD_W = PAY_W + 1;

  logic [WORD_W-1:0] sreg;
  logic              sclk_q;
  logic              le_q;

  wire shift_en = ser_clk & ~sclk_q & ~ser_le;
  wire load_en  = ser_le & ~le_q;
  wire [PAY_W-1:0] pay = sreg[WORD_W-1:1];
  wire addr = sreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg   <= '0;
      sclk_q <= 1'b1;
      le_q   <= 1'b1;
    end else begin
      sclk_q <= ser_clk;
      le_q   <= ser_le;
      if (shift_en) sreg <= {sreg[WORD_W-2:0], ser_data};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {idle_bit, n_val, a_val} <= '0;
    end else if (load_en && !addr) begin
      {idle_bit, n_val, a_val} <= pay;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cp_bits, ctl_bits, r_val} <= '0;
    end else if (load_en && addr) begin
      {cp_bits, ctl_bits, r_val} <= pay;
    end
  end
endmodule

// File: rtl/serial_prog_port_chk.sv
module serial_prog_port_chk #(
  parameter int A_W  = 4,
  parameter int N_W  = 12,
  parameter int R_W  = 11,
  parameter int CT_W = 3,
  parameter int CP_W = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ser_clk,
  input logic                    ser_data,
  input logic                    ser_le,
  input logic [A_W+N_W+1:0]      sreg,
  input logic                    sclk_q,
  input logic                    le_q,
  input logic [A_W-1:0]          a_val,
  input logic [N_W-1:0]          n_val,
  input logic                    idle_bit,
  input logic [R_W-1:0]          r_val,
  input logic [CT_W-1:0]         ctl_bits,
  input logic [CP_W-1:0]         cp_bits
);
  localparam int WORD_W = A_W + N_W + 2;

  wire [A_W+N_W:0]       grp_an = {idle_bit, n_val, a_val};
  wire [R_W+CT_W+CP_W-1:0] grp_r = {cp_bits, ctl_bits, r_val};

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (grp_an == '0 && grp_r == '0));

  // R2
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && !sclk_q && !ser_le) |=> sreg == {$past(sreg[WORD_W-2:0]), $past(ser_data)});

  // R3
  no_shift_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_le |=> $stable(sreg));

  // R4
  load_an_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_le && !le_q && !sreg[0]) |=> grp_an == $past(sreg[WORD_W-1:1]));

  // R5
  load_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_le && !le_q && sreg[0]) |=> grp_r == $past(sreg[WORD_W-1:1]));

  // R6
  one_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(grp_an) |-> $stable(grp_r));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ser_le && !le_q) |=> ($stable(grp_an) && $stable(grp_r)));
endmodule

bind serial_prog_port serial_prog_port_chk #(
  .A_W(A_W), .N_W(N_W), .R_W(R_W), .CT_W(CT_W), .CP_W(CP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
  .ser_le(ser_le), .sreg(sreg), .sclk_q(sclk_q), .le_q(le_q),
  .a_val(a_val), .n_val(n_val), .idle_bit(idle_bit), .r_val(r_val),
  .ctl_bits(ctl_bits), .cp_bits(cp_bits)
);

// File: tb/tb_serial_prog_port.sv
module tb_serial_prog_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0;
  logic ser_data = 1'b0;
  logic ser_le = 1'b1;
  logic [3:0]  a_val;
  logic [11:0] n_val;
  logic        idle_bit;
  logic [10:0] r_val;
  logic [2:0]  ctl_bits;
  logic [2:0]  cp_bits;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [17:0] m_sreg = '0;
  logic [3:0]  m_a = '0;
  logic [11:0] m_n = '0;
  logic        m_idle = 1'b0;
  logic [10:0] m_r = '0;
  logic [2:0]  m_ctl = '0;
  logic [2:0]  m_cp = '0;

  always #10 clk = ~clk;

  serial_prog_port dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_le(ser_le), .a_val(a_val), .n_val(n_val), .idle_bit(idle_bit),
    .r_val(r_val), .ctl_bits(ctl_bits), .cp_bits(cp_bits)
  );

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    check(tag, "a_val", int'(a_val), int'(m_a));
    check(tag, "n_val", int'(n_val), int'(m_n));
    check(tag, "idle_bit", int'(idle_bit), int'(m_idle));
    check(tag, "r_val", int'(r_val), int'(m_r));
    check(tag, "ctl_bits", int'(ctl_bits), int'(m_ctl));
    check(tag, "cp_bits", int'(cp_bits), int'(m_cp));
  endtask

  function automatic logic [17:0] mk_an(logic [3:0] a, logic [11:0] n, logic idle);
    return {idle, n, a, 1'b0};
  endfunction

  function automatic logic [17:0] mk_r(logic [10:0] r, logic [2:0] ct, logic [2:0] cp);
    return {cp, ct, r, 1'b1};
  endfunction

  task automatic model_load();
    if (!m_sreg[0]) {m_idle, m_n, m_a} = m_sreg[17:1];
    else            {m_cp, m_ctl, m_r} = m_sreg[17:1];
  endtask

  task automatic send_bit(logic b);
    @(negedge clk);
    ser_data = b;
    ser_clk = 1'b1;
    if (!ser_le) m_sreg = {m_sreg[16:0], b};
    @(negedge clk);
    ser_clk = 1'b0;
  endtask

  task automatic open_word();
    @(negedge clk);
    ser_le = 1'b0;
  endtask

  task automatic close_word(string tag);
    @(negedge clk);
    ser_le = 1'b1;
    model_load();
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic close_with_edge(string tag, logic b);
    @(negedge clk);
    ser_data = b;
    ser_clk = 1'b1;
    ser_le = 1'b1;
    model_load();
    @(negedge clk);
    ser_clk = 1'b0;
    check_all(tag);
  endtask

  task automatic send_word(logic [17:0] w, int len);
    for (int i = 0; i < len - 18; i++) send_bit(1'($urandom));
    for (int i = 17; i >= 0; i--) if (i < len) send_bit(w[i]);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R2 R4: full word to the divider group
    open_word();
    send_word(mk_an(4'h9, 12'hA5C, 1'b1), 18);
    close_word("R4");
    // R5 R6: reference group, divider group untouched
    open_word();
    send_word(mk_r(11'h5A3, 3'h6, 3'h3), 18);
    close_word("R5");
    check("R6", "n_val kept", int'(n_val), 32'hA5C);
    // R2: single bits MSB first, checked through fields
    open_word();
    send_word(mk_an(4'h1, 12'h800, 1'b0), 18);
    close_word("R2");
    // R3: edges while enable high do nothing, then short word
    for (int i = 0; i < 6; i++) send_bit(1'($urandom));
    open_word();
    send_word(18'h0_0003, 5);
    close_word("R3");
    // R7: overlong word
    open_word();
    send_word(mk_r(11'h7FF, 3'h1, 3'h7), 23);
    close_word("R7");
    // R8: bits with enable low, no rise yet
    open_word();
    send_word(mk_an(4'hF, 12'hFFF, 1'b1), 18);
    check_all("R8");
    // R10: load visible one clk after rise
    close_word("R10");
    // R9: coincident edge and enable rise
    open_word();
    send_word(mk_r(11'h123, 3'h2, 3'h5), 18);
    close_with_edge("R9", 1'b0);

    for (int t = 0; t < 60; t++) begin
      int len = 12 + int'($urandom % 12);
      logic [17:0] w = 18'($urandom);
      open_word();
      send_word(w, len);
      if ($urandom % 4 == 0) close_with_edge("R9", 1'($urandom));
      else                   close_word("R7");
      if ($urandom % 3 == 0) begin
        for (int k = 0; k < 3; k++) send_bit(1'($urandom));
        check_all("R8");
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule